// File: doc/BRIEF.md
# Controller Command Block Processor

This block services a 64-byte shared command RAM used to talk to game controllers. Software fills the RAM with a packed sequence of per-channel frames, sets the scan-enable bit in the last byte (the control byte) and pulses `start_i`. The engine then walks the first 63 bytes one at a time through a byte-wide port with a combinational read. It classifies each frame header, reads the receive-length byte and the command code, and writes the reply bytes back into the same RAM. The reply is either a fixed identity triple or a live copy of the four controller state bytes.

Header codes mark idle channels, padding and the end of the block, and a receive byte can also terminate the scan. A running channel count is exported. An unsupported command code sets a sticky error and ends the scan. After the scan, or at once when scanning is not enabled, a finishing step rewrites the control byte according to its upper command bits. `done_o` then rises and stays high until the next start.

Top module: `joy_cmd_engine`

## Requirements
- R1: A `start_i` pulse while idle begins a pass. `busy_o` is high and `done_o` low for the whole pass. At the end `done_o` rises and holds until the next accepted start. A `start_i` seen during a pass is ignored.
- R2: When bit 0 of byte 63 is clear at start, no byte 0..62 is written and the channel count stays 0. Only the finishing step of R12 runs.
- R3: The scan reads headers at indices 0..62, using the low 6 bits only. Header value 0x00 or 0x3D adds one to the channel count and moves to the next byte. Value 0x3F is skipped with no count change. Value 0x3E ends the scan.
- R4: Any other header value is the transmit length T, and the following byte is the receive byte. If that byte with bit 7 forced to 1 equals 0xFE (raw 0x7E or 0xFE), the scan ends. Otherwise its low 6 bits are the receive length L.
- R5: The command code is the byte right after the receive byte, at index C. Code 0x00 or 0xFF writes 0x05, 0x00, 0x01 to indices C+T, C+T+1, C+T+2.
- R6: Command 0xFF adds one extra count, so the frame adds two to the channel count in total.
- R7: Command 0x01 writes the controller state to C+T onward, most significant byte first: `pad_state_i[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`.
- R8: Commands 0x02 and 0x03 write nothing and add one to the channel count.
- R9: After a supported frame, the next header is read at C+T+L, and the channel count rises by one. Reply bytes already written there are parsed as data. The scan ends once the index reaches 63.
- R10: Any other command code sets `err_o` and ends the scan without a channel increment. `err_o` stays set until reset.
- R11: Reply bytes whose index would be 63 or above are not written.
- R12: Finishing step: if bit 4 or bit 5 of the start-time control byte is set, byte 63 becomes 0x80. Otherwise, if bit 3 is set, byte 63 becomes the control byte with bit 3 cleared. Otherwise byte 63 is not written.
- R13: After reset `busy_o`, `done_o`, `err_o`, `ram_we_o` are 0 and `chan_o` is 0. No RAM write occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a pass (accepted while idle) |
| pad_state_i | input | 32 | Live controller state, first reply byte in [31:24] |
| ram_rdata_i | input | 8 | Read data for `ram_addr_o`, same cycle |
| ram_addr_o | output | 6 | RAM byte index |
| ram_we_o | output | 1 | RAM write enable, write at the next clock edge |
| ram_wdata_o | output | 8 | RAM write data |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Last pass complete |
| err_o | output | 1 | Sticky unsupported-command flag |
| chan_o | output | 7 | Channel count of the current or last pass |

## Verification
The bench targets several corner cases, and a faulty design would show each one differently. Header bytes are fed with their top bits set, so a design that decodes all eight bits would miss the idle and padding codes. A frame is placed near the end of the RAM, so a design that wraps reply addresses would corrupt the control byte. Transmit lengths are chosen so that the next header lands on freshly written reply bytes, and an index slip of one would then parse a different chain. The receive byte is given as 0x7E to catch a missing bit-7 force. The 0xFF command must add two to the channel count. An unsupported code is followed by a clean pass, so an error flag that clears on start is caught. Randomised images check the whole RAM and the count after each pass.

// File: rtl/joy_cmd_pkg.sv
package joy_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_HDR, ST_RX, ST_CMD, ST_REPLY, ST_ADV, ST_FIN
  } eng_state_e;

  typedef enum logic [1:0] {HDR_CHAN, HDR_STOP, HDR_SKIP, HDR_FRAME} hdr_kind_e;
  typedef enum logic [1:0] {RPL_NONE, RPL_IDENT, RPL_PAD, RPL_BAD} rpl_kind_e;

  localparam logic [5:0] TX_IDLE_A = 6'h00;
  localparam logic [5:0] TX_IDLE_B = 6'h3D;
  localparam logic [5:0] TX_STOP   = 6'h3E;
  localparam logic [5:0] TX_SKIP   = 6'h3F;
  localparam logic [7:0] RX_FORCE  = 8'h80;
  localparam logic [7:0] RX_STOP   = 8'hFE;
  localparam logic [7:0] CMD_INFO  = 8'h00;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_POLL  = 8'h01;
  localparam logic [7:0] CMD_RD    = 8'h02;
  localparam logic [7:0] CMD_WR    = 8'h03;
  localparam logic [7:0] ID_B0     = 8'h05;
  localparam logic [7:0] ID_B1     = 8'h00;
  localparam logic [7:0] ID_B2     = 8'h01;
  localparam logic [7:0] CTRL_DONE = 8'h80;
  localparam int unsigned ID_LEN   = 3;
endpackage

// File: rtl/joy_hdr_decode.sv
module joy_hdr_decode
  import joy_cmd_pkg::*;
(
  input  logic [5:0] hdr_i,
  output hdr_kind_e  kind_o
);
  always_comb begin
    if (hdr_i == TX_IDLE_A || hdr_i == TX_IDLE_B) kind_o = HDR_CHAN;
    else if (hdr_i == TX_STOP)                    kind_o = HDR_STOP;
    else if (hdr_i == TX_SKIP)                    kind_o = HDR_SKIP;
    else                                          kind_o = HDR_FRAME;
  end
endmodule

// File: rtl/joy_cmd_decode.sv
module joy_cmd_decode
  import joy_cmd_pkg::*;
(
  input  logic [7:0] cmd_i,
  output rpl_kind_e  kind_o,
  output logic       extra_chan_o
);
  always_comb begin
    extra_chan_o = (cmd_i == CMD_RESET);
    unique case (cmd_i)
      CMD_INFO, CMD_RESET: kind_o = RPL_IDENT;
      CMD_POLL:            kind_o = RPL_PAD;
      CMD_RD, CMD_WR:      kind_o = RPL_NONE;
      default:             kind_o = RPL_BAD;
    endcase
  end
endmodule

// File: rtl/joy_reply_mux.sv
module joy_reply_mux
  import joy_cmd_pkg::*;
#(
  parameter int unsigned PAD_BYTES = 4,
  parameter int unsigned BEAT_W    = 3
) (
  input  rpl_kind_e               kind_i,
  input  logic [BEAT_W-1:0]       beat_i,
  input  logic [8*PAD_BYTES-1:0]  pad_state_i,
  output logic [7:0]              byte_o
);
  logic [7:0] pad_b [PAD_BYTES];

  for (genvar g = 0; g < PAD_BYTES; g++) begin : g_pad
    assign pad_b[g] = pad_state_i[8*(PAD_BYTES-g)-1 -: 8];
  end

  always_comb begin
    byte_o = '0;
    if (kind_i == RPL_IDENT) begin
      case (beat_i)
        BEAT_W'(0): byte_o = ID_B0;
        BEAT_W'(1): byte_o = ID_B1;
        default:    byte_o = ID_B2;
      endcase
    end else if (kind_i == RPL_PAD) begin
      for (int k = 0; k < PAD_BYTES; k++)
        if (beat_i == BEAT_W'(k)) byte_o = pad_b[k];
    end
  end
endmodule

// File: rtl/joy_ctrl_finish.sv
module joy_ctrl_finish
  import joy_cmd_pkg::*;
(
  input  logic [7:0] ctrl_i,
  output logic       we_o,
  output logic [7:0] wdata_o
);
  always_comb begin
    if (ctrl_i[5] || ctrl_i[4]) begin
      we_o    = 1'b1;
      wdata_o = CTRL_DONE;
    end else if (ctrl_i[3]) begin
      we_o    = 1'b1;
      wdata_o = ctrl_i & ~8'h08;
    end else begin
      we_o    = 1'b0;
      wdata_o = ctrl_i;
    end
  end
endmodule

// File: rtl/joy_cmd_engine.sv
module joy_cmd_engine
  import joy_cmd_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 64,
  parameter int unsigned PAD_BYTES = 4,
  parameter int unsigned CHAN_W    = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [8*PAD_BYTES-1:0]        pad_state_i,
  input  logic [7:0]                    ram_rdata_i,
  output logic [$clog2(RAM_DEPTH)-1:0]  ram_addr_o,
  output logic                          ram_we_o,
  output logic [7:0]                    ram_wdata_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic [CHAN_W-1:0]             chan_o
);
  localparam int unsigned AW     = $clog2(RAM_DEPTH);
  localparam int unsigned IDX_W  = AW + 2;
  localparam int unsigned BEAT_W = $clog2((PAD_BYTES > ID_LEN ? PAD_BYTES : ID_LEN) + 1);
  localparam logic [AW-1:0]    CTRL_IDX = AW'(RAM_DEPTH - 1);
  localparam logic [IDX_W-1:0] SCAN_END = IDX_W'(RAM_DEPTH - 1);

  eng_state_e        state_q;
  logic [IDX_W-1:0]  idx_q, base_q, wr_idx;
  logic [5:0]        tx_q, rx_q;
  logic [BEAT_W-1:0] beat_q, last_q;
  rpl_kind_e         kind_q, cmd_kind;
  logic [7:0]        ctrl_q, rx_forced, reply_byte, fin_byte;
  logic [CHAN_W-1:0] chan_q;
  logic              err_q, done_q, extra_chan, fin_we;
  hdr_kind_e         hdr_kind;

  joy_hdr_decode u_hdr (.hdr_i(ram_rdata_i[5:0]), .kind_o(hdr_kind));

  joy_cmd_decode u_cmd (
    .cmd_i(ram_rdata_i), .kind_o(cmd_kind), .extra_chan_o(extra_chan)
  );

  joy_reply_mux #(.PAD_BYTES(PAD_BYTES), .BEAT_W(BEAT_W)) u_reply (
    .kind_i(kind_q), .beat_i(beat_q), .pad_state_i(pad_state_i), .byte_o(reply_byte)
  );

  joy_ctrl_finish u_fin (.ctrl_i(ctrl_q), .we_o(fin_we), .wdata_o(fin_byte));

  assign wr_idx    = base_q + IDX_W'(beat_q);
  assign rx_forced = ram_rdata_i | RX_FORCE;

  always_comb begin
    ram_addr_o  = '0;
    ram_we_o    = 1'b0;
    ram_wdata_o = reply_byte;
    unique case (state_q)
      ST_CTRL:              ram_addr_o = CTRL_IDX;
      ST_HDR, ST_RX, ST_CMD: ram_addr_o = idx_q[AW-1:0];
      ST_REPLY: begin
        ram_addr_o = wr_idx[AW-1:0];
        ram_we_o   = (wr_idx < SCAN_END);  // never reach the control byte
      end
      ST_FIN: begin
        ram_addr_o  = CTRL_IDX;
        ram_we_o    = fin_we;
        ram_wdata_o = fin_byte;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      kind_q  <= RPL_NONE;
      ctrl_q  <= '0;
      chan_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          done_q  <= 1'b0;
          state_q <= ST_CTRL;
        end
        ST_CTRL: begin
          ctrl_q  <= ram_rdata_i;
          idx_q   <= '0;
          chan_q  <= '0;
          state_q <= ram_rdata_i[0] ? ST_HDR : ST_FIN;
        end
        ST_HDR: begin
          if (idx_q >= SCAN_END) begin
            state_q <= ST_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
            unique case (hdr_kind)
              HDR_CHAN:  chan_q <= chan_q + 1'b1;
              HDR_STOP:  state_q <= ST_FIN;
              HDR_SKIP:  ;
              HDR_FRAME: begin
                tx_q    <= ram_rdata_i[5:0];
                state_q <= ST_RX;
              end
            endcase
          end
        end
        ST_RX: begin
          idx_q <= idx_q + 1'b1;
          if (rx_forced == RX_STOP) begin
            state_q <= ST_FIN;
          end else begin
            rx_q    <= ram_rdata_i[5:0];
            state_q <= ST_CMD;
          end
        end
        ST_CMD: begin
          base_q <= idx_q + IDX_W'(tx_q);
          beat_q <= '0;
          kind_q <= cmd_kind;
          if (extra_chan) chan_q <= chan_q + 1'b1;
          unique case (cmd_kind)
            RPL_BAD: begin
              err_q   <= 1'b1;
              state_q <= ST_FIN;
            end
            RPL_NONE:  state_q <= ST_ADV;
            RPL_IDENT: begin
              last_q  <= BEAT_W'(ID_LEN - 1);
              state_q <= ST_REPLY;
            end
            RPL_PAD: begin
              last_q  <= BEAT_W'(PAD_BYTES - 1);
              state_q <= ST_REPLY;
            end
          endcase
        end
        ST_REPLY: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == last_q) state_q <= ST_ADV;
        end
        ST_ADV: begin
          idx_q   <= idx_q + IDX_W'(tx_q) + IDX_W'(rx_q);
          chan_q  <= chan_q + 1'b1;
          state_q <= ST_HDR;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign chan_o = chan_q;

  // R1: done and busy never overlap; done only rises out of a pass
  assert_done_busy_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  assert_done_after_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  // R3: padding header leaves the count alone
  assert_skip_no_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR && idx_q < SCAN_END && hdr_kind == HDR_SKIP) |=> $stable(chan_o));
  // R6: reset-type command counts once at decode
  assert_reset_cmd_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && ram_rdata_i == CMD_RESET) |=> chan_o == $past(chan_o) + 1'b1);
  // R10: error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R11: reply writes stay below the control byte
  assert_reply_below_ctrl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && state_q == ST_REPLY) |-> ram_addr_o != CTRL_IDX);
  // R13: no write while idle
  assert_idle_no_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_we_o);
endmodule

// File: tb/joy_cmd_engine_bench.sv
`timescale 1ns/1ps
module joy_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pad = '0;
  logic [7:0]  rdata, wdata;
  logic [5:0]  addr;
  logic        we, busy, done, err;
  logic [6:0]  chan;

  logic [7:0] mem [64];
  logic [7:0] img [64];
  logic [7:0] exp_mem [64];
  int         exp_chan;
  bit         exp_err = 1'b0;
  int         checks = 0, fails = 0, ctrl_writes = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  joy_cmd_engine u_joy_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pad_state_i(pad),
    .ram_rdata_i(rdata), .ram_addr_o(addr), .ram_we_o(we), .ram_wdata_o(wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .chan_o(chan)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) begin
    mem[addr] <= wdata;
    if (addr == 6'd63) ctrl_writes++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle monitor (R1, R13)
  always @(negedge clk) if (rst_n && !finished) begin
    chk(!(we && !busy), "R13", "write while idle", we, 0);
    chk(!(busy && done), "R1", "done during pass", done, 0);
  end

  task automatic put(input int i, input logic [7:0] v);
    if (i < 63) exp_mem[i] = v;
  endtask

  task automatic model();
    logic [7:0] ctrl, r, cmd;
    int i, c, t, rl, base, ch;
    bit stop;
    for (int k = 0; k < 64; k++) exp_mem[k] = img[k];
    ctrl = exp_mem[63];
    ch = 0; i = 0; stop = 0;
    if (ctrl[0]) begin
      while (i < 63 && !stop) begin
        c = i; i++;
        t = exp_mem[c] & 8'h3F;
        if (t == 0 || t == 8'h3D) ch++;
        else if (t == 8'h3E) stop = 1;
        else if (t == 8'h3F) ;
        else begin
          r = exp_mem[i] | 8'h80; i++;
          if (r == 8'hFE) stop = 1;
          else begin
            rl = r & 8'h3F;
            cmd = exp_mem[i & 63];
            base = i + t;
            if (cmd == 8'h00 || cmd == 8'hFF) begin
              put(base, 8'h05); put(base + 1, 8'h00); put(base + 2, 8'h01);
              if (cmd == 8'hFF) ch++;
            end else if (cmd == 8'h01) begin
              put(base, pad[31:24]); put(base + 1, pad[23:16]);
              put(base + 2, pad[15:8]); put(base + 3, pad[7:0]);
            end else if (cmd != 8'h02 && cmd != 8'h03) begin
              exp_err = 1; stop = 1;
            end
            if (!stop) begin i += t + rl; ch++; end
          end
        end
      end
    end
    if (ctrl[5] || ctrl[4]) exp_mem[63] = 8'h80;
    else if (ctrl[3]) exp_mem[63] = ctrl & ~8'h08;
    exp_chan = ch;
  endtask

  task automatic fill(input logic [7:0] ctrl);
    for (int k = 0; k < 63; k++) img[k] = 8'h3F;
    img[63] = ctrl;
  endtask

  task automatic run_pass(input string req, input bit mid_start);
    int n;
    @(negedge clk);
    for (int k = 0; k < 64; k++) mem[k] = img[k];
    model();
    ctrl_writes = 0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !done, req, "pass started", {busy, done}, 2'b10);
    if (mid_start) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    chk(done && !busy, req, "done", {busy, done}, 2'b01);
    for (int k = 0; k < 64; k++)
      chk(mem[k] == exp_mem[k], req, $sformatf("byte %0d", k), mem[k], exp_mem[k]);
    chk(chan == 7'(exp_chan), req, "channel count", chan, exp_chan);
    chk(err == exp_err, req, "error flag", err, exp_err);
    chk(ctrl_writes <= 1, req, "control writes", ctrl_writes, 1);
    // idle afterwards: done holds (R1)
    repeat (3) @(negedge clk);
    chk(done && !busy, "R1", "done held", done, 1);
  endtask

  initial begin
    logic [7:0] pick [8] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h3F, 8'hFF, 8'h02, 8'h41};
    for (int k = 0; k < 64; k++) mem[k] = 8'h3F;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(!busy && !done && !err && !we && chan == 0, "R13", "reset state",
        {busy, done, err, we, chan}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pad = 32'hA1B2C3D4;

    // R2, R12: scan disabled, bit 3 cleared, frames untouched
    fill(8'h08);
    img[0] = 8'h01; img[1] = 8'h04; img[2] = 8'h01;
    run_pass("R2", 0);

    // R3, R5, R7, R9: idle, pad, poll frame, identity frame, stop
    fill(8'h01);
    img[0] = 8'h00; img[1] = 8'h3F; img[2] = 8'h01; img[3] = 8'h04; img[4] = 8'h01;
    img[9] = 8'h3D; img[10] = 8'h01; img[11] = 8'h03; img[12] = 8'h00; img[16] = 8'h3E;
    run_pass("R7", 0);

    // R6, R12: reset-type command, control forced to 0x80
    fill(8'h31);
    img[0] = 8'h01; img[1] = 8'h03; img[2] = 8'hFF; img[6] = 8'h3E;
    run_pass("R6", 0);

    // R4: receive byte 0x7E and 0xFE end the scan
    fill(8'h01);
    img[0] = 8'h01; img[1] = 8'h7E; img[2] = 8'h00; img[3] = 8'h03; img[4] = 8'h00;
    run_pass("R4", 0);
    fill(8'h09);
    img[0] = 8'h3D; img[1] = 8'h02; img[2] = 8'hFE; img[3] = 8'h00;
    run_pass("R4", 0);

    // R8: no-reply commands
    fill(8'h01);
    img[0] = 8'h01; img[1] = 8'h00; img[2] = 8'h02;
    img[3] = 8'h01; img[4] = 8'h00; img[5] = 8'h03; img[6] = 8'h3E;
    run_pass("R8", 0);

    // R11: reply runs off the end
    fill(8'h01);
    img[58] = 8'h01; img[59] = 8'h04; img[60] = 8'h01;
    run_pass("R11", 0);

    // R3, R9: header top bits ignored, chained onto reply bytes, extra start ignored (R1)
    fill(8'h01);
    img[0] = 8'h40; img[1] = 8'h05; img[2] = 8'h02; img[3] = 8'h00;
    run_pass("R9", 1);

    // R10: unsupported command, then a clean pass keeps the flag
    fill(8'h09);
    img[0] = 8'h01; img[1] = 8'h01; img[2] = 8'h07; img[5] = 8'h00;
    run_pass("R10", 0);
    fill(8'h01);
    img[0] = 8'h01; img[1] = 8'h04; img[2] = 8'h01; img[7] = 8'h3E;
    run_pass("R10", 0);

    // R9: randomised images
    for (int p = 0; p < 24; p++) begin
      pad = $urandom;
      for (int k = 0; k < 63; k++) img[k] = pick[$urandom_range(0, 7)];
      img[63] = 8'($urandom_range(0, 255)) | 8'h01;
      run_pass("R9", 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule